// File: doc/BRIEF.md
# Symbol Energy Signal-Strength Generator

After every dump of the integrate-and-dump filters, this block takes the complex symbol (I, Q). It computes the symbol energy I² + Q² and turns the result into two pulse-width-modulated signal-strength outputs for the code-tracking processor. The level output always shows the energy of the current symbol. The track output depends on a mode input. With the mode input low (acquisition), it carries the same energy. With the mode input high (tracking), it carries the difference between the current energy and the energy of a symbol a programmable number of symbols back. A mid-scale offset is added so that negative differences can also be shown.

The arithmetic runs on a slow calculation clock enable, derived from the main clock by a selectable divider. Each result takes ten enable ticks. Each output word passes through a right shift (the output gain) and a clamp to the PWM range. It is then loaded into its modulator at the next period boundary. A small energy history buffer holds the past energies. It is wiped when the block leaves tracking.

Top module: `rssi_energy_gen`

## Requirements
- R1: The level output carries min(E >> out_shift, 2^PWM_W − 1), where E = sym_i² + sym_q² of the most recently accepted symbol.
- R2: With track_en low when the symbol is accepted, the track output carries the same word as the level output.
- R3: With track_en high, the track output carries clamp(2^(PWM_W−1) + ((E − E_old) >>> out_shift)). E_old is the energy of the accepted symbol dither_lag symbols earlier. A dither_lag of 0 gives a difference of zero.
- R4: The energy history reads as zero after reset and after every high-to-low change of track_en. Symbols accepted after the clear still fill the history.
- R5: The out_shift value scales the energy and the difference. It does not scale the mid-scale offset.
- R6: Results are clamped to 0 … 2^PWM_W − 1 at both ends.
- R7: Each modulator has a free-running PWM_W-bit counter. The counter holds k mod 2^PWM_W on the k-th clock after reset. The output is high while counter < word. A new word takes effect only when the counter wraps to 0.
- R8: A symbol is accepted on a rising edge of sym_dump while no calculation is running. Edges that arrive during a calculation are ignored, and so are their samples.
- R9: A result is ready 10 calculation ticks after acceptance. One tick lasts 8 << dsp_div clock cycles (8, 16, 32 or 64).
- R10: After reset both outputs are low until a symbol has been processed and loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_dump | input | 1 | Dump strobe; rising edge offers a new symbol |
| sym_i | input | SAMPLE_W (12) | Signed in-phase filter output |
| sym_q | input | SAMPLE_W (12) | Signed quadrature filter output |
| track_en | input | 1 | High selects tracking (difference) mode |
| dither_lag | input | LAG_W (4) | Symbol distance for the energy difference |
| out_shift | input | GAIN_W (4) | Right shift applied to energy and difference |
| dsp_div | input | DIVSEL_W (2) | Calculation tick divider select |
| rssi_trk_pwm | output | 1 | Track (dither-difference) PWM output |
| rssi_lvl_pwm | output | 1 | Level (current energy) PWM output |

## Verification
The bound checker checks some properties on every cycle. A modulator word may change only at counter wrap, and a zero word keeps its output low. The latched symbol stays still while a calculation runs. Every result is ready exactly ten ticks of the selected divider after acceptance, and in acquisition the two result words are equal. The bench scenarios are the only way to show the numeric results: the exact duty count for energy, gain, both clamps, the signed track difference at several lags, the history wipe on leaving tracking, and a dump ignored during a busy calculation leaving no trace in the history.

// File: rtl/rssi_pkg.sv
package rssi_pkg;

    // Number of calculation ticks per symbol
    localparam int unsigned CALC_TICKS    = 10;
    // Smallest divider is 2**DIV_BASE_LOG2
    localparam int unsigned DIV_BASE_LOG2 = 3;

    typedef enum logic [3:0] {
        ST_SQI     = 4'd0,
        ST_SQQ     = 4'd1,
        ST_SUM     = 4'd2,
        ST_HIST    = 4'd3,
        ST_DIFF    = 4'd4,
        ST_SCALE   = 4'd5,
        ST_SEL     = 4'd6,
        ST_CLAMP   = 4'd7,
        ST_HOLD    = 4'd8,
        ST_PUBLISH = 4'd9
    } calc_step_e;

endpackage

// File: rtl/rssi_dsp_tick.sv
module rssi_dsp_tick import rssi_pkg::*; #(
    parameter int unsigned DIVSEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic [DIVSEL_W-1:0] sel,
    output logic                tick
);
    localparam int unsigned CNT_W = DIV_BASE_LOG2 + (2 ** DIVSEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_t;

    tick_t t_d, t_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'((1 << (DIV_BASE_LOG2 + int'(sel))) - 1);
        t_d   = t_q;
        tick  = 1'b0;
        if (restart) begin
            t_d.cnt = '0;
        end else if (t_q.cnt == limit) begin
            t_d.cnt = '0;
            tick    = 1'b1;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/rssi_energy_hist.sv
module rssi_energy_hist #(
    parameter int unsigned EW    = 24,
    parameter int unsigned LAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [EW-1:0]    din,
    input  logic [LAG_W-1:0] lag,
    output logic [EW-1:0]    old
);
    localparam int unsigned DEPTH = 2 ** LAG_W;

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [LAG_W-1:0]         wp;
    } hist_t;

    hist_t h_d, h_q;
    logic [LAG_W-1:0] rd_idx;

    always_comb begin
        // wp points at the next free slot; wp-1 is one symbol back
        rd_idx = h_q.wp - lag;
        old    = h_q.mem[rd_idx];
        h_d    = h_q;
        if (clr) begin
            h_d = '0;
        end else if (push) begin
            h_d.mem[h_q.wp] = din;
            h_d.wp          = h_q.wp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end
endmodule

// File: rtl/rssi_pwm_chan.sv
module rssi_pwm_chan #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_req,
    input  logic [W-1:0] word_in,
    output logic         pwm_o,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] word_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] word;
        logic [W-1:0] pend;
        logic         pend_v;
    } pwm_t;

    pwm_t p_d, p_q;

    always_comb begin
        p_d     = p_q;
        p_d.cnt = p_q.cnt + 1'b1;
        if (load_req) begin
            p_d.pend   = word_in;
            p_d.pend_v = 1'b1;
        end
        if (p_q.cnt == '1) begin
            if (load_req) begin
                p_d.word   = word_in;
                p_d.pend_v = 1'b0;
            end else if (p_q.pend_v) begin
                p_d.word   = p_q.pend;
                p_d.pend_v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign pwm_o  = (p_q.cnt < p_q.word);
    assign cnt_o  = p_q.cnt;
    assign word_o = p_q.word;
endmodule

// File: rtl/rssi_energy_gen.sv
module rssi_energy_gen import rssi_pkg::*; #(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned PWM_W    = 16,
    parameter int unsigned LAG_W    = 4,
    parameter int unsigned GAIN_W   = 4,
    parameter int unsigned DIVSEL_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sym_dump,
    input  logic signed [SAMPLE_W-1:0] sym_i,
    input  logic signed [SAMPLE_W-1:0] sym_q,
    input  logic                       track_en,
    input  logic [LAG_W-1:0]           dither_lag,
    input  logic [GAIN_W-1:0]          out_shift,
    input  logic [DIVSEL_W-1:0]        dsp_div,
    output logic                       rssi_trk_pwm,
    output logic                       rssi_lvl_pwm
);
    localparam int unsigned EW = 2 * SAMPLE_W;   // energy width
    localparam int unsigned DW = EW + 1;         // signed difference
    localparam int unsigned RW = EW + 2;         // signed with offset
    localparam int unsigned NCH = 2;
    localparam logic signed [RW-1:0] MID_OFS = RW'(2 ** (PWM_W - 1));
    localparam logic signed [RW-1:0] MAX_VAL = RW'((2 ** PWM_W) - 1);

    typedef struct packed {
        logic                       busy;
        calc_step_e                 step;
        logic                       trk;
        logic [GAIN_W-1:0]          gain;
        logic [LAG_W-1:0]           lag;
        logic [DIVSEL_W-1:0]        dsel;
        logic signed [SAMPLE_W-1:0] x;
        logic signed [SAMPLE_W-1:0] y;
        logic [EW-1:0]              sqx;
        logic [EW-1:0]              sqy;
        logic [EW-1:0]              nrg;
        logic [EW-1:0]              old;
        logic signed [DW-1:0]       diff;
        logic [EW-1:0]              sc_nrg;
        logic signed [DW-1:0]       sc_diff;
        logic signed [RW-1:0]       r1;
        logic signed [RW-1:0]       r2;
        logic [PWM_W-1:0]           w1;
        logic [PWM_W-1:0]           w2;
        logic                       dump_prev;
        logic                       trk_prev;
        logic                       publish;
    } calc_t;

    calc_t s_d, s_q;

    logic             trig;
    logic             tick;
    logic             hist_push;
    logic             trk_fall;
    logic [EW-1:0]    hist_old;
    logic [NCH-1:0]   pwm_bus;
    logic [PWM_W-1:0] pub_word [NCH];
    logic [PWM_W-1:0] pwm_cnt  [NCH];
    logic [PWM_W-1:0] pwm_word [NCH];

    function automatic logic [EW-1:0] square(input logic signed [SAMPLE_W-1:0] v);
        logic signed [EW-1:0] p;
        p = EW'(v) * EW'(v);
        return $unsigned(p);
    endfunction

    function automatic logic [PWM_W-1:0] clamp(input logic signed [RW-1:0] v);
        if (v < 0)            return '0;
        else if (v > MAX_VAL) return '1;
        else                  return v[PWM_W-1:0];
    endfunction

    assign trk_fall = s_q.trk_prev & ~track_en;

    always_comb begin
        s_d           = s_q;
        s_d.publish   = 1'b0;
        s_d.dump_prev = sym_dump;
        s_d.trk_prev  = track_en;
        hist_push     = 1'b0;
        trig          = sym_dump & ~s_q.dump_prev & ~s_q.busy;

        if (trig) begin
            s_d.busy = 1'b1;
            s_d.step = ST_SQI;
            s_d.x    = sym_i;
            s_d.y    = sym_q;
            s_d.trk  = track_en;
            s_d.gain = out_shift;
            s_d.lag  = dither_lag;
            s_d.dsel = dsp_div;
        end else if (s_q.busy && tick) begin
            case (s_q.step)
                ST_SQI:   s_d.sqx = square(s_q.x);
                ST_SQQ:   s_d.sqy = square(s_q.y);
                ST_SUM:   s_d.nrg = s_q.sqx + s_q.sqy;
                ST_HIST: begin
                    s_d.old   = (s_q.lag == '0) ? s_q.nrg : hist_old;
                    hist_push = 1'b1;
                end
                ST_DIFF:  s_d.diff = $signed({1'b0, s_q.nrg}) - $signed({1'b0, s_q.old});
                ST_SCALE: begin
                    s_d.sc_nrg  = s_q.nrg >> s_q.gain;
                    s_d.sc_diff = s_q.diff >>> s_q.gain;
                end
                ST_SEL: begin
                    s_d.r2 = $signed({2'b00, s_q.sc_nrg});
                    s_d.r1 = s_q.trk ? (MID_OFS + RW'(s_q.sc_diff))
                                     : $signed({2'b00, s_q.sc_nrg});
                end
                ST_CLAMP: begin
                    s_d.w1 = clamp(s_q.r1);
                    s_d.w2 = clamp(s_q.r2);
                end
                ST_HOLD:  ;
                ST_PUBLISH: begin
                    s_d.publish = 1'b1;
                    s_d.busy    = 1'b0;
                end
                default:  s_d.busy = 1'b0;
            endcase
            if (s_q.step != ST_PUBLISH) s_d.step = calc_step_e'(s_q.step + 4'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    rssi_dsp_tick #(.DIVSEL_W(DIVSEL_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (trig),
        .sel     (s_q.dsel),
        .tick    (tick)
    );

    rssi_energy_hist #(.EW(EW), .LAG_W(LAG_W)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (trk_fall),
        .push  (hist_push),
        .din   (s_q.nrg),
        .lag   (s_q.lag),
        .old   (hist_old)
    );

    assign pub_word[0] = s_q.w1;
    assign pub_word[1] = s_q.w2;

    for (genvar g = 0; g < NCH; g++) begin : g_pwm
        rssi_pwm_chan #(.W(PWM_W)) u_pwm (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_req (s_q.publish),
            .word_in  (pub_word[g]),
            .pwm_o    (pwm_bus[g]),
            .cnt_o    (pwm_cnt[g]),
            .word_o   (pwm_word[g])
        );
    end

    assign rssi_trk_pwm = pwm_bus[0];
    assign rssi_lvl_pwm = pwm_bus[1];
endmodule

// File: rtl/rssi_energy_chk.sv
module rssi_energy_chk import rssi_pkg::*; #(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned PWM_W    = 16,
    parameter int unsigned DIVSEL_W = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       trig,
    input logic                       busy,
    input logic                       publish,
    input logic                       trk_job,
    input logic [DIVSEL_W-1:0]        dsel,
    input logic signed [SAMPLE_W-1:0] x_job,
    input logic [PWM_W-1:0]           w1,
    input logic [PWM_W-1:0]           w2,
    input logic [PWM_W-1:0]           cnt0,
    input logic [PWM_W-1:0]           cnt1,
    input logic [PWM_W-1:0]           word0,
    input logic [PWM_W-1:0]           word1,
    input logic                       pwm0,
    input logic                       pwm1
);
    logic [15:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           lat_q <= '0;
        else if (trig)        lat_q <= '0;
        else if (lat_q != '1) lat_q <= lat_q + 1'b1;
    end

    p_load_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word0) |-> $past(cnt0) == '1);
    p_load_at_wrap_lvl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word1) |-> $past(cnt1) == '1);
    p_zero_word_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (word0 == '0 && word1 == '0) |-> (!pwm0 && !pwm1));
    p_hold_job_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(x_job));
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        publish |-> lat_q == 16'(CALC_TICKS << (DIV_BASE_LOG2 + int'(dsel))));
    p_slip_same_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (publish && !trk_job) |-> w1 == w2);
endmodule

bind rssi_energy_gen rssi_energy_chk #(
    .SAMPLE_W (SAMPLE_W),
    .PWM_W    (PWM_W),
    .DIVSEL_W (DIVSEL_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (trig),
    .busy    (s_q.busy),
    .publish (s_q.publish),
    .trk_job (s_q.trk),
    .dsel    (s_q.dsel),
    .x_job   (s_q.x),
    .w1      (s_q.w1),
    .w2      (s_q.w2),
    .cnt0    (pwm_cnt[0]),
    .cnt1    (pwm_cnt[1]),
    .word0   (pwm_word[0]),
    .word1   (pwm_word[1]),
    .pwm0    (pwm_bus[0]),
    .pwm1    (pwm_bus[1])
);

// File: tb/tb_rssi_energy_gen.sv
module tb_rssi_energy_gen;
    localparam int SW  = 8;
    localparam int PW  = 8;
    localparam int PER = 2 ** PW;
    localparam int MID = 2 ** (PW - 1);
    localparam int MAXV = PER - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sym_dump = 1'b0;
    logic signed [SW-1:0] sym_i = '0;
    logic signed [SW-1:0] sym_q = '0;
    logic                 track_en = 1'b0;
    logic [3:0]           dither_lag = 4'd1;
    logic [3:0]           out_shift = 4'd0;
    logic [1:0]           dsp_div = 2'd0;
    logic                 rssi_trk_pwm, rssi_lvl_pwm;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;
    int mh [16];

    always #5 clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    rssi_energy_gen #(.SAMPLE_W(SW), .PWM_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .sym_dump(sym_dump), .sym_i(sym_i), .sym_q(sym_q),
        .track_en(track_en), .dither_lag(dither_lag), .out_shift(out_shift),
        .dsp_div(dsp_div), .rssi_trk_pwm(rssi_trk_pwm), .rssi_lvl_pwm(rssi_lvl_pwm)
    );

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    function automatic int clampv(input int v);
        if (v < 0) return 0;
        if (v > MAXV) return MAXV;
        return v;
    endfunction

    task automatic model_clear();
        for (int k = 0; k < 16; k++) mh[k] = 0;
    endtask

    // Expected words for an accepted symbol; pushes it into the model history
    task automatic model_sym(input int x, input int y, output int e1, output int e2);
        int e, old;
        e   = x * x + y * y;
        e2  = clampv(e >>> out_shift);
        old = (dither_lag == 0) ? e : mh[dither_lag - 1];
        if (track_en) e1 = clampv(MID + ((e - old) >>> out_shift));
        else          e1 = e2;
        for (int k = 15; k > 0; k--) mh[k] = mh[k - 1];
        mh[0] = e;
    endtask

    task automatic to_wrap();
        while (cyc % PER != 0) @(negedge clk);
    endtask

    task automatic do_symbol(input int x, input int y);
        to_wrap();
        sym_i = SW'(x);
        sym_q = SW'(y);
        sym_dump = 1'b1;
        repeat (3) @(negedge clk);
        sym_dump = 1'b0;
        @(negedge clk);
    endtask

    task automatic measure(output int h1, output int h2);
        to_wrap();
        h1 = 0;
        h2 = 0;
        for (int k = 0; k < PER; k++) begin
            h1 += int'(rssi_trk_pwm);
            h2 += int'(rssi_lvl_pwm);
            @(negedge clk);
        end
    endtask

    task automatic run_sym(input int x, input int y, input string r_trk, input string r_lvl);
        int e1, e2, h1, h2;
        model_sym(x, y, e1, e2);
        do_symbol(x, y);
        measure(h1, h2);
        check(r_trk, h1, e1);
        check(r_lvl, h2, e2);
    endtask

    task automatic t_reset();
        int h1, h2;
        measure(h1, h2);
        check("R10 trk low after reset", h1, 0);
        check("R10 lvl low after reset", h2, 0);
    endtask

    task automatic t_slip_level();
        track_en = 0; out_shift = 0;
        run_sym(5, -7, "R2 slip trk equals energy", "R1 R7 lvl energy duty");
        run_sym(-3, 2, "R2 slip trk second", "R1 lvl second");
    endtask

    task automatic t_gain();
        out_shift = 2;
        run_sym(9, 4, "R2 R5 slip trk shifted", "R5 lvl shifted");
        out_shift = 0;
    endtask

    task automatic t_clamp_high();
        run_sym(-128, -128, "R6 trk clamp high", "R6 lvl clamp high");
    endtask

    task automatic t_track_diff();
        track_en = 1; dither_lag = 1;
        @(negedge clk);
        run_sym(3, 4, "R6 R3 trk clamp low", "R1 lvl in track");
        run_sym(3, 4, "R3 trk zero diff mid", "R1 lvl repeat");
        dither_lag = 2;
        run_sym(6, 8, "R3 trk lag two", "R1 lvl lag two");
    endtask

    task automatic t_track_gain();
        out_shift = 1; dither_lag = 1;
        run_sym(2, 0, "R5 offset not scaled", "R5 lvl shift one");
        out_shift = 0;
    endtask

    task automatic t_lag_zero();
        dither_lag = 0;
        run_sym(7, 1, "R3 lag zero mid", "R1 lvl lag zero");
    endtask

    task automatic t_slip_clear();
        track_en = 0;
        @(negedge clk);
        model_clear();
        run_sym(1, 1, "R2 slip after clear", "R1 lvl after clear");
        track_en = 1; dither_lag = 2;
        @(negedge clk);
        run_sym(3, 0, "R4 history cleared", "R1 lvl clear test");
    endtask

    task automatic t_busy_ignore();
        int e1, e2, h1, h2;
        track_en = 0;
        @(negedge clk);
        model_clear();
        model_sym(4, 0, e1, e2);
        do_symbol(4, 0);
        repeat (20) @(negedge clk);
        sym_i = 8'sd10; sym_q = 8'sd10;
        sym_dump = 1'b1;
        repeat (3) @(negedge clk);
        sym_dump = 1'b0;
        measure(h1, h2);
        check("R8 busy dump ignored trk", h1, e1);
        check("R8 busy dump ignored lvl", h2, e2);
        track_en = 1; dither_lag = 1;
        @(negedge clk);
        run_sym(0, 0, "R8 ignored dump not in history", "R1 lvl zero energy");
    endtask

    task automatic t_latency();
        int e1, e2, h1, h2, p1, p2;
        track_en = 0;
        dsp_div = 2'd3;
        @(negedge clk);
        model_clear();
        measure(p1, p2);
        model_sym(3, 3, e1, e2);
        do_symbol(3, 3);
        measure(h1, h2);
        check("R9 old word first period", h2, p2);
        measure(h1, h2);
        check("R9 old word second period", h2, p2);
        measure(h1, h2);
        check("R9 new word after ten slow ticks", h2, e2);
        check("R9 trk after ten slow ticks", h1, e1);
        dsp_div = 2'd0;
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_slip_level();
        t_gain();
        t_clamp_high();
        t_track_diff();
        t_track_gain();
        t_lag_zero();
        t_slip_clear();
        t_busy_ignore();
        t_latency();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired got=%0d exp=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule